// File: doc/BRIEF.md
# Watchpoint Address-Value Register Bank

This block keeps the address values that the debug watchpoints of a processor core compare against. It holds a parameterised number of 64-bit entries, up to 64. It accepts system-register move requests and identifies the ones addressed to it by their five encoding fields. It forms an entry index from the low index field and, when the extended-debug feature is present, from a 2-bit bank selector. Every request then passes a prioritised permission ladder that depends on the current exception level and on a set of trap, lock and feature configuration inputs.

Each request that hits the bank produces exactly one outcome: the access is performed, the access is undefined, it traps to EL2, it traps to EL3, or the core enters debug halt. The outcome is reported one cycle after the request strobe as a one-hot status vector, together with a trap syndrome class and the read data. Only a performed access changes or returns register contents. The bits above the top address bit are returned as sign-extension copies of that bit. Where the top address bit lies depends on the large-address feature inputs.

Top module: `wpt_value_bank`

## Requirements
- R1: A request is accepted only when op0=2'b10, op1=3'b000, CRn=4'b0000 and op2=3'b110. An accepted request raises `rsp_valid` in the cycle after `req_valid`. A request with any other encoding gives no response and changes no entry.
- R2: The effective index is `{bank_sel, req_crm}` when `ext_dbg_feat` is 1, and `req_crm` otherwise. An index that is not below `NUM_WP` is undefined. This check has priority over every other check, at every exception level.
- R3: Every accepted request with `cur_el`=0 is undefined.
- R4: At `cur_el`=1 the first matching rule decides the outcome, in this order:
  - `el3_impl & sdd_undef_first & el3_dbg_trap` gives undefined.
  - `el2_on & fgt_feat & (!el3_impl | el3_fgt_en) & <direction fine-grained bit>` gives trap to EL2.
  - `el2_on & (el2_trap_all | el2_dbg_trap)` gives trap to EL2.
  - `el3_impl & el3_dbg_trap` gives undefined when `sdd_undef` is 1, and trap to EL3 otherwise.
  - `!os_lock & halt_ok & ext_dbg_trap` gives halt.
  - If no rule matches, the access is performed.
- R5: Reads test only `fgt_rd_trap` and writes test only `fgt_wr_trap`. The fine-grained bit of the other direction has no effect.
- R6: At `cur_el`=2 the R4 ladder applies with both EL2 trap rules left out.
- R7: At `cur_el`=3 only the halt rule is applied. Otherwise the access is performed.
- R8: `rsp_status` is one-hot when `rsp_valid` is 1 and zero otherwise. The bit assignment is: bit0 performed, bit1 undefined, bit2 trap to EL2, bit3 trap to EL3, bit4 halt. `rsp_syndrome` is 6'h18 on either trap and 0 in every other case.
- R9: A performed write stores `req_wdata`. A performed read returns the stored entry on `rsp_rdata`. `rsp_rdata` is zero for every other response.
- R10: Bits [1:0] of every entry read as zero, whatever was written to them.
- R11: The top address bit is bit 56 when `lva3_feat` is 1, bit 52 when only `lva_feat` is 1, and bit 48 otherwise. A read returns every bit above the top address bit as a copy of it.
- R12: A write that ends undefined, trapped or halted leaves the entry unchanged.
- R13: After reset `rsp_valid` is 0 and every entry reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm, low entry index |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 64 | Write value |
| bank_sel | input | 2 | Bank of 16 entries when extended debug is present |
| cur_el | input | 2 | Current exception level |
| ext_dbg_feat | input | 1 | Extended-debug feature (banked indexing) |
| lva_feat | input | 1 | Large address feature, bits [52:49] |
| lva3_feat | input | 1 | Larger address feature, bits [56:49] |
| el3_impl | input | 1 | EL3 is implemented |
| el2_on | input | 1 | EL2 is enabled |
| sdd_undef_first | input | 1 | Secure-debug undefined takes priority |
| sdd_undef | input | 1 | Secure-debug undefined instead of EL3 trap |
| el3_dbg_trap | input | 1 | EL3 debug-access trap bit |
| fgt_feat | input | 1 | Fine-grained trap feature present |
| el3_fgt_en | input | 1 | EL3 enable for fine-grained traps |
| fgt_rd_trap | input | 1 | Fine-grained trap for reads |
| fgt_wr_trap | input | 1 | Fine-grained trap for writes |
| el2_trap_all | input | 1 | EL2 routes all debug to EL2 |
| el2_dbg_trap | input | 1 | EL2 debug-access trap bit |
| os_lock | input | 1 | OS lock set |
| halt_ok | input | 1 | Halting allowed |
| ext_dbg_trap | input | 1 | External debugger trap bit |
| rsp_valid | output | 1 | Response valid |
| rsp_status | output | 5 | One-hot outcome |
| rsp_syndrome | output | 6 | Trap syndrome class |
| rsp_rdata | output | 64 | Read data |

## Verification
The assertions check several properties on every cycle:
- the status is one-hot exactly when a response is valid;
- a response follows only a matching request;
- the syndrome class goes with the trap bits;
- the two low data bits stay zero;
- non-performed responses carry zero data;
- EL0 requests and out-of-range indices resolve as undefined;
- an EL3 request without the halt condition is performed.

The bench scenarios show the full ladder order at EL1 and EL2, the direction split of the fine-grained bits, and the banked index arithmetic. They also show sign-extension at each address width and that a blocked write leaves the stored value intact. These need a reference memory and the exact rung that wins, which per-cycle properties do not hold.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

  localparam int unsigned VAL_W    = 64;
  localparam int unsigned FULL_IW  = 6;
  localparam int unsigned N_OUT    = 5;
  localparam int unsigned TOP_BASE = 48;
  localparam int unsigned TOP_LVA  = 52;
  localparam int unsigned TOP_LVA3 = 56;

  localparam logic [1:0] ENC_OP0 = 2'b10;
  localparam logic [2:0] ENC_OP1 = 3'b000;
  localparam logic [3:0] ENC_CRN = 4'b0000;
  localparam logic [2:0] ENC_OP2 = 3'b110;

  localparam logic [5:0] TRAP_CLASS = 6'h18;

  typedef enum logic [2:0] {
    OUT_DONE     = 3'd0,
    OUT_UNDEF    = 3'd1,
    OUT_TRAP_EL2 = 3'd2,
    OUT_TRAP_EL3 = 3'd3,
    OUT_HALT     = 3'd4
  } outcome_e;

  typedef struct packed {
    logic el3_impl;
    logic el2_on;
    logic sdd_undef_first;
    logic sdd_undef;
    logic el3_dbg_trap;
    logic fgt_feat;
    logic el3_fgt_en;
    logic fgt_rd_trap;
    logic fgt_wr_trap;
    logic el2_trap_all;
    logic el2_dbg_trap;
    logic os_lock;
    logic halt_ok;
    logic ext_dbg_trap;
  } gate_cfg_t;

endpackage

// File: rtl/wpt_req_decode.sv
module wpt_req_decode
  import wpt_pkg::*;
#(
  parameter int unsigned NUM_WP = 20,
  parameter int unsigned AW     = 5
) (
  input  logic [1:0]    op0,
  input  logic [2:0]    op1,
  input  logic [3:0]    crn,
  input  logic [3:0]    crm,
  input  logic [2:0]    op2,
  input  logic [1:0]    bank_sel,
  input  logic          ext_dbg,
  output logic          hit,
  output logic          in_range,
  output logic [AW-1:0] addr
);

  logic [FULL_IW-1:0] eff_idx;

  assign hit = (op0 == ENC_OP0) && (op1 == ENC_OP1) &&
               (crn == ENC_CRN) && (op2 == ENC_OP2);

  // banked index only with the extended-debug feature
  assign eff_idx  = ext_dbg ? {bank_sel, crm} : {2'b00, crm};
  assign in_range = 32'(eff_idx) < NUM_WP;
  assign addr     = eff_idx[AW-1:0];

endmodule

// File: rtl/wpt_access_gate.sv
module wpt_access_gate
  import wpt_pkg::*;
(
  input  logic [1:0] cur_el,
  input  logic       is_write,
  input  logic       in_range,
  input  gate_cfg_t  cfg,
  output outcome_e   outcome
);

  logic fgt_bit;
  logic r_sdd_first;
  logic r_fgt;
  logic r_el2;
  logic r_el3;
  logic r_halt;
  outcome_e el3_kind;

  assign fgt_bit     = is_write ? cfg.fgt_wr_trap : cfg.fgt_rd_trap;
  assign r_sdd_first = cfg.el3_impl & cfg.sdd_undef_first & cfg.el3_dbg_trap;
  assign r_fgt       = cfg.el2_on & cfg.fgt_feat &
                       (~cfg.el3_impl | cfg.el3_fgt_en) & fgt_bit;
  assign r_el2       = cfg.el2_on & (cfg.el2_trap_all | cfg.el2_dbg_trap);
  assign r_el3       = cfg.el3_impl & cfg.el3_dbg_trap;
  assign r_halt      = ~cfg.os_lock & cfg.halt_ok & cfg.ext_dbg_trap;
  assign el3_kind    = cfg.sdd_undef ? OUT_UNDEF : OUT_TRAP_EL3;

  always_comb begin
    outcome = OUT_DONE;
    if (!in_range) begin
      outcome = OUT_UNDEF;
    end else begin
      unique case (cur_el)
        2'd0: outcome = OUT_UNDEF;
        2'd1: begin
          if (r_sdd_first)  outcome = OUT_UNDEF;
          else if (r_fgt)   outcome = OUT_TRAP_EL2;
          else if (r_el2)   outcome = OUT_TRAP_EL2;
          else if (r_el3)   outcome = el3_kind;
          else if (r_halt)  outcome = OUT_HALT;
          else              outcome = OUT_DONE;
        end
        2'd2: begin
          if (r_sdd_first)  outcome = OUT_UNDEF;
          else if (r_el3)   outcome = el3_kind;
          else if (r_halt)  outcome = OUT_HALT;
          else              outcome = OUT_DONE;
        end
        default: begin
          if (r_halt)       outcome = OUT_HALT;
          else              outcome = OUT_DONE;
        end
      endcase
    end
  end

endmodule

// File: rtl/wpt_value_store.sv
module wpt_value_store #(
  parameter int unsigned NUM_WP = 20,
  parameter int unsigned VAL_W  = 64,
  parameter int unsigned AW     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [VAL_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [VAL_W-1:0] rd_data,
  output logic             rd_live
);

  // plain array, no reset: maps onto block RAM
  logic [VAL_W-1:0]  mem [NUM_WP];
  // per-entry flag gives the zero reset view
  logic [NUM_WP-1:0] live;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live    <= '0;
      rd_live <= 1'b0;
    end else begin
      if (wr_en) live[wr_addr] <= 1'b1;
      if (rd_en) rd_live <= live[rd_addr];
    end
  end

endmodule

// File: rtl/wpt_read_shape.sv
module wpt_read_shape
  import wpt_pkg::*;
(
  input  logic             en,
  input  logic             live,
  input  logic             lva,
  input  logic             lva3,
  input  logic [VAL_W-1:0] raw,
  output logic [VAL_W-1:0] shaped
);

  logic [VAL_W-1:0] ext;
  logic             top52;
  logic             top56;

  assign top52 = lva  ? raw[TOP_LVA]  : raw[TOP_BASE];
  assign top56 = lva3 ? raw[TOP_LVA3] : top52;

  for (genvar b = 0; b < VAL_W; b++) begin : g_bit
    if (b <= TOP_BASE) begin : g_addr
      assign ext[b] = raw[b];
    end else if (b <= TOP_LVA) begin : g_lva
      assign ext[b] = (lva | lva3) ? raw[b] : raw[TOP_BASE];
    end else if (b <= TOP_LVA3) begin : g_lva3
      assign ext[b] = lva3 ? raw[b] : top52;
    end else begin : g_sign
      assign ext[b] = top56;
    end
  end

  assign shaped = (en && live) ? ext : '0;

endmodule

// File: rtl/wpt_value_bank.sv
module wpt_value_bank
  import wpt_pkg::*;
#(
  parameter int unsigned NUM_WP = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_op0,
  input  logic [2:0]  req_op1,
  input  logic [3:0]  req_crn,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_op2,
  input  logic [63:0] req_wdata,
  input  logic [1:0]  bank_sel,
  input  logic [1:0]  cur_el,
  input  logic        ext_dbg_feat,
  input  logic        lva_feat,
  input  logic        lva3_feat,
  input  logic        el3_impl,
  input  logic        el2_on,
  input  logic        sdd_undef_first,
  input  logic        sdd_undef,
  input  logic        el3_dbg_trap,
  input  logic        fgt_feat,
  input  logic        el3_fgt_en,
  input  logic        fgt_rd_trap,
  input  logic        fgt_wr_trap,
  input  logic        el2_trap_all,
  input  logic        el2_dbg_trap,
  input  logic        os_lock,
  input  logic        halt_ok,
  input  logic        ext_dbg_trap,
  output logic        rsp_valid,
  output logic [4:0]  rsp_status,
  output logic [5:0]  rsp_syndrome,
  output logic [63:0] rsp_rdata
);

  localparam int unsigned AW = (NUM_WP > 1) ? $clog2(NUM_WP) : 1;
  localparam logic [VAL_W-1:0] LOW_MASK = ~64'h3;

  logic          hit;
  logic          in_range;
  logic [AW-1:0] addr;
  gate_cfg_t     cfg;
  outcome_e      outcome;
  logic          take;
  logic          do_write;
  logic          do_read;
  logic          is_trap;

  logic [VAL_W-1:0] store_q;
  logic             live_q;
  logic             rd_done_q;
  logic             lva_q;
  logic             lva3_q;

  wpt_req_decode #(.NUM_WP(NUM_WP), .AW(AW)) u_decode (
    .op0      (req_op0),
    .op1      (req_op1),
    .crn      (req_crn),
    .crm      (req_crm),
    .op2      (req_op2),
    .bank_sel (bank_sel),
    .ext_dbg  (ext_dbg_feat),
    .hit      (hit),
    .in_range (in_range),
    .addr     (addr)
  );

  assign cfg = '{
    el3_impl:        el3_impl,
    el2_on:          el2_on,
    sdd_undef_first: sdd_undef_first,
    sdd_undef:       sdd_undef,
    el3_dbg_trap:    el3_dbg_trap,
    fgt_feat:        fgt_feat,
    el3_fgt_en:      el3_fgt_en,
    fgt_rd_trap:     fgt_rd_trap,
    fgt_wr_trap:     fgt_wr_trap,
    el2_trap_all:    el2_trap_all,
    el2_dbg_trap:    el2_dbg_trap,
    os_lock:         os_lock,
    halt_ok:         halt_ok,
    ext_dbg_trap:    ext_dbg_trap
  };

  wpt_access_gate u_gate (
    .cur_el   (cur_el),
    .is_write (req_write),
    .in_range (in_range),
    .cfg      (cfg),
    .outcome  (outcome)
  );

  assign take     = req_valid & hit;
  assign do_write = take & req_write & (outcome == OUT_DONE);
  assign do_read  = take & ~req_write & (outcome == OUT_DONE);
  assign is_trap  = (outcome == OUT_TRAP_EL2) || (outcome == OUT_TRAP_EL3);

  wpt_value_store #(.NUM_WP(NUM_WP), .VAL_W(VAL_W), .AW(AW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (do_write),
    .wr_addr (addr),
    .wr_data (req_wdata & LOW_MASK),
    .rd_en   (do_read),
    .rd_addr (addr),
    .rd_data (store_q),
    .rd_live (live_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_status   <= '0;
      rsp_syndrome <= '0;
      rd_done_q    <= 1'b0;
      lva_q        <= 1'b0;
      lva3_q       <= 1'b0;
    end else begin
      rsp_valid    <= take;
      rsp_status   <= take ? (5'b00001 << outcome) : 5'b00000;
      rsp_syndrome <= (take && is_trap) ? TRAP_CLASS : 6'h00;
      rd_done_q    <= do_read;
      if (do_read) begin
        lva_q  <= lva_feat;
        lva3_q <= lva3_feat;
      end
    end
  end

  wpt_read_shape u_shape (
    .en     (rd_done_q),
    .live   (live_q),
    .lva    (lva_q),
    .lva3   (lva3_q),
    .raw    (store_q),
    .shaped (rsp_rdata)
  );

endmodule

// File: rtl/wpt_bank_checker.sv
module wpt_bank_checker #(
  parameter int unsigned NUM_WP = 20
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [1:0]  req_op0,
  input logic [2:0]  req_op1,
  input logic [3:0]  req_crn,
  input logic [3:0]  req_crm,
  input logic [2:0]  req_op2,
  input logic [1:0]  bank_sel,
  input logic [1:0]  cur_el,
  input logic        ext_dbg_feat,
  input logic        os_lock,
  input logic        halt_ok,
  input logic        ext_dbg_trap,
  input logic        rsp_valid,
  input logic [4:0]  rsp_status,
  input logic [5:0]  rsp_syndrome,
  input logic [63:0] rsp_rdata
);

  logic       req_hit;
  logic [5:0] idx_full;
  logic       idx_ok;
  logic       halt_cond;

  assign req_hit   = req_valid && req_op0 == 2'b10 && req_op1 == 3'b000 &&
                     req_crn == 4'b0000 && req_op2 == 3'b110;
  assign idx_full  = ext_dbg_feat ? {bank_sel, req_crm} : {2'b00, req_crm};
  assign idx_ok    = 32'(idx_full) < NUM_WP;
  assign halt_cond = !os_lock && halt_ok && ext_dbg_trap;

  a_r8_status_onehot: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones(rsp_status) == 1);

  a_r8_status_idle: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> rsp_status == 5'b00000);

  a_r1_resp_needs_hit: assert property (@(posedge clk) disable iff (rst)
    req_hit |=> rsp_valid);

  a_r1_no_stray_resp: assert property (@(posedge clk) disable iff (rst)
    !req_hit |=> !rsp_valid);

  a_r8_trap_class: assert property (@(posedge clk) disable iff (rst)
    (rsp_status[2] || rsp_status[3]) |-> rsp_syndrome == 6'h18);

  a_r8_no_class: assert property (@(posedge clk) disable iff (rst)
    !(rsp_status[2] || rsp_status[3]) |-> rsp_syndrome == 6'h00);

  a_r10_low_bits: assert property (@(posedge clk) disable iff (rst)
    rsp_rdata[1:0] == 2'b00);

  a_r9_quiet_data: assert property (@(posedge clk) disable iff (rst)
    !rsp_status[0] |-> rsp_rdata == 64'd0);

  a_r3_el0_undef: assert property (@(posedge clk) disable iff (rst)
    (req_hit && cur_el == 2'd0) |=> rsp_status == 5'b00010);

  a_r2_range_first: assert property (@(posedge clk) disable iff (rst)
    (req_hit && !idx_ok) |=> rsp_status == 5'b00010);

  a_r7_el3_done: assert property (@(posedge clk) disable iff (rst)
    (req_hit && idx_ok && cur_el == 2'd3 && !halt_cond) |=> rsp_status == 5'b00001);

endmodule

bind wpt_value_bank wpt_bank_checker #(.NUM_WP(NUM_WP)) u_wpt_chk (.*);

// File: tb/tb_wpt_value_bank.sv
`timescale 1ns/1ps
module tb_wpt_value_bank;

  localparam int unsigned NUM_WP = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_op0 = 2'b10;
  logic [2:0]  req_op1 = 3'b000;
  logic [3:0]  req_crn = 4'b0000;
  logic [3:0]  req_crm = 4'd0;
  logic [2:0]  req_op2 = 3'b110;
  logic [63:0] req_wdata = '0;
  logic [1:0]  bank_sel = 2'd0;
  logic [1:0]  cur_el = 2'd1;
  logic ext_dbg_feat = 0, lva_feat = 0, lva3_feat = 0;
  logic el3_impl = 0, el2_on = 0, sdd_undef_first = 0, sdd_undef = 0;
  logic el3_dbg_trap = 0, fgt_feat = 0, el3_fgt_en = 0;
  logic fgt_rd_trap = 0, fgt_wr_trap = 0, el2_trap_all = 0, el2_dbg_trap = 0;
  logic os_lock = 0, halt_ok = 0, ext_dbg_trap = 0;
  logic        rsp_valid;
  logic [4:0]  rsp_status;
  logic [5:0]  rsp_syndrome;
  logic [63:0] rsp_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 0;
  logic [63:0] ref_mem [64];

  wpt_value_bank #(.NUM_WP(NUM_WP)) dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic [3:0] crm, input logic [1:0] bk,
                        input logic [1:0] el, input logic [63:0] wd);
    @(negedge clk);
    req_write = wr; req_crm = crm; bank_sel = bk; cur_el = el; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [63:0] norm(input logic [63:0] v, input logic lva, input logic lva3);
    int top;
    logic [63:0] r;
    top = lva3 ? 56 : (lva ? 52 : 48);
    r = v & ~64'h3;
    for (int b = 0; b < 64; b++) if (b > top) r[b] = v[top];
    return r;
  endfunction

  // status index: 0 done, 1 undef, 2 trap EL2, 3 trap EL3, 4 halt
  function automatic int exp_out(input logic [1:0] el, input logic wr, input logic inr);
    logic fb;
    logic halt_c;
    fb = wr ? fgt_wr_trap : fgt_rd_trap;
    halt_c = !os_lock && halt_ok && ext_dbg_trap;
    if (!inr) return 1;
    if (el == 0) return 1;
    if (el == 3) return halt_c ? 4 : 0;
    if (el3_impl && sdd_undef_first && el3_dbg_trap) return 1;
    if (el == 1) begin
      if (el2_on && fgt_feat && (!el3_impl || el3_fgt_en) && fb) return 2;
      if (el2_on && (el2_trap_all || el2_dbg_trap)) return 2;
    end
    if (el3_impl && el3_dbg_trap) return sdd_undef ? 1 : 3;
    if (halt_c) return 4;
    return 0;
  endfunction

  task automatic clear_cfg();
    el3_impl = 0; el2_on = 0; sdd_undef_first = 0; sdd_undef = 0; el3_dbg_trap = 0;
    fgt_feat = 0; el3_fgt_en = 0; fgt_rd_trap = 0; fgt_wr_trap = 0;
    el2_trap_all = 0; el2_dbg_trap = 0; os_lock = 0; halt_ok = 0; ext_dbg_trap = 0;
    ext_dbg_feat = 0; lva_feat = 0; lva3_feat = 0;
  endtask

  // performed request with full checking against the reference
  task automatic access(input string tag, input logic wr, input logic [3:0] crm,
                        input logic [1:0] bk, input logic [1:0] el, input logic [63:0] wd);
    int idx, eo;
    logic inr;
    logic [63:0] ed;
    idx = ext_dbg_feat ? (int'(bk) * 16 + int'(crm)) : int'(crm);
    inr = idx < NUM_WP;
    eo = exp_out(el, wr, inr);
    ed = (!wr && eo == 0) ? norm(ref_mem[idx], lva_feat, lva3_feat) : 64'd0;
    do_req(wr, crm, bk, el, wd);
    if (wr && eo == 0) ref_mem[idx] = wd & ~64'h3;
    chk(rsp_valid === 1'b1, {tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk(rsp_status === (5'b00001 << eo), {tag, " status"}, 64'(rsp_status), 64'(5'b00001 << eo));
    chk(rsp_syndrome === ((eo == 2 || eo == 3) ? 6'h18 : 6'h00), {tag, " R8 syndrome"},
        64'(rsp_syndrome), (eo == 2 || eo == 3) ? 64'h18 : 64'h0);
    chk(rsp_rdata === ed, {tag, " data"}, rsp_rdata, ed);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk(rsp_valid === 1'b0 && rsp_status === 5'd0, "R13 reset outputs", 64'(rsp_status), 64'd0);
    for (int i = 0; i < 16; i++) access("R13 reset read", 1'b0, 4'(i), 2'd0, 2'd3, 64'd0);

    // Ladder sweep: R3 R4 R5 R6 R7 R8 R9 R12
    for (int el = 0; el < 4; el++) begin
      for (int c = 0; c < 8192; c++) begin
        logic wr;
        logic [12:0] cb;
        string tg;
        cb = 13'(c);
        wr = ^cb;
        el3_impl = cb[0]; el2_on = cb[1]; sdd_undef_first = cb[2]; sdd_undef = cb[3];
        el3_dbg_trap = cb[4]; fgt_feat = cb[5]; el3_fgt_en = cb[6];
        fgt_rd_trap = wr ? ~cb[7] : cb[7];   // R5: other direction opposite
        fgt_wr_trap = wr ? cb[7] : ~cb[7];
        el2_trap_all = cb[8]; el2_dbg_trap = cb[9]; os_lock = cb[10];
        halt_ok = cb[11]; ext_dbg_trap = cb[12];
        tg = (el == 0) ? "R3 sweep" : (el == 1) ? "R4/R5 sweep" : (el == 2) ? "R6 sweep" : "R7 sweep";
        access({tg, " R9 R12"}, wr, cb[3:0] ^ cb[7:4], 2'd0, 2'(el),
               {16'(c), 16'(~c), 16'(c * 3), 16'(c * 5 + 1)});
      end
    end
    clear_cfg();

    // R1 encoding decode
    access("R1 base write", 1'b1, 4'd7, 2'd0, 2'd1, 64'h0000_1234_5678_9ab0);
    for (int f = 0; f < 4; f++) begin
      if (f == 0) req_op0 = 2'b11;
      if (f == 1) req_op1 = 3'b001;
      if (f == 2) req_crn = 4'b0001;
      if (f == 3) req_op2 = 3'b100;
      do_req(1'b1, 4'd7, 2'd0, 2'd1, 64'hffff_ffff_ffff_fff0);
      chk(rsp_valid === 1'b0, "R1 foreign encoding no response", 64'(rsp_valid), 64'd0);
      req_op0 = 2'b10; req_op1 = 3'b000; req_crn = 4'b0000; req_op2 = 3'b110;
    end
    access("R1 entry unchanged", 1'b0, 4'd7, 2'd0, 2'd1, 64'd0);

    // R2 banked index
    ext_dbg_feat = 1;
    access("R2 bank1 idx19 write", 1'b1, 4'd3, 2'd1, 2'd1, 64'h0000_aaaa_5555_0004);
    access("R2 bank1 idx20 undef", 1'b1, 4'd4, 2'd1, 2'd1, 64'h1);
    access("R2 bank1 idx19 read", 1'b0, 4'd3, 2'd1, 2'd1, 64'd0);
    access("R2 bank0 idx3 read", 1'b0, 4'd3, 2'd0, 2'd1, 64'd0);
    halt_ok = 1; ext_dbg_trap = 1;
    access("R2 range before halt at EL3", 1'b0, 4'd15, 2'd3, 2'd3, 64'd0);
    halt_ok = 0; ext_dbg_trap = 0;
    el2_on = 1; el2_trap_all = 1;
    access("R2 range before EL2 trap", 1'b0, 4'd0, 2'd2, 2'd1, 64'd0);
    clear_cfg();
    access("R2 no bank without feature", 1'b0, 4'd3, 2'd3, 2'd1, 64'd0);

    // R10 low bits
    access("R10 write low bits", 1'b1, 4'd9, 2'd0, 2'd2, 64'h0000_0000_0000_00ff);
    access("R10 read low bits", 1'b0, 4'd9, 2'd0, 2'd2, 64'd0);

    // R11 sign extension by width
    access("R11 write", 1'b1, 4'd11, 2'd0, 2'd3, 64'h0101_0000_0000_1234);
    access("R11 base width", 1'b0, 4'd11, 2'd0, 2'd3, 64'd0);
    lva_feat = 1;
    access("R11 lva width", 1'b0, 4'd11, 2'd0, 2'd3, 64'd0);
    lva3_feat = 1;
    access("R11 lva3 width", 1'b0, 4'd11, 2'd0, 2'd3, 64'd0);
    lva_feat = 0;
    access("R11 lva3 alone", 1'b0, 4'd11, 2'd0, 2'd3, 64'd0);
    lva3_feat = 0;

    // R12 blocked write then readback
    el3_impl = 1; el3_dbg_trap = 1;
    access("R12 trapped write", 1'b1, 4'd11, 2'd0, 2'd2, 64'hdead_beef_0000_0000);
    clear_cfg();
    access("R12 readback", 1'b0, 4'd11, 2'd0, 2'd2, 64'd0);

    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(8ns * 190000);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule